// File: doc/BRIEF.md
# Alignment and Branch-Target Exception Router

This block sits beside the instruction pipeline and produces exception records for three kinds of fault. It checks the current instruction address for word alignment and raises a program-counter alignment exception when the address is misaligned. It also accepts a stack-pointer misalignment request and a branch-target violation request from elsewhere in the core. The block does not detect stack-pointer misalignment itself.

For each exception the block picks the exception level that takes it. It also forms the preferred return address, the faulting virtual address and a 25-bit syndrome. Each fault class has its own routing rule, which depends on the current level, an EL2-enabled flag and a trap-general control bit. The branch-target syndrome carries the 2-bit branch type of the offending branch.

The result is registered and appears one cycle after the request, qualified by a single-cycle valid strobe. If several requests arrive in the same cycle, a fixed priority chooses one of them.

Top module: `excRouter`

## Requirements
- R1: When `instValid` is 1 and `instAddr[1:0]` is not 00, a program-counter alignment exception is raised with class code 1. An address with bits [1:0] equal to 00, or `instValid` equal to 0, raises nothing.
- R2: For the alignment classes (program counter, code 1; stack pointer, code 3), the target level is chosen in this order:
  - the current level, if it is 2 or 3;
  - otherwise level 2, if `el2Enable` and `trapGeneral` are both 1;
  - otherwise level 1.
- R3: For the branch-target class (code 2), the target level is chosen in this order:
  - level 2, only if the current level is 0 and `el2Enable` and `trapGeneral` are both 1;
  - otherwise the current level, if it is 2 or 3;
  - otherwise level 1. A branch-target fault at level 1 therefore stays at level 1.
- R4: A branch-target syndrome holds `btType` in bits [1:0] and zero in bits [24:2]. The syndrome is all zero for both alignment classes.
- R5: The faulting virtual address equals the instruction address for a program-counter alignment exception and is zero for the other two classes.
- R6: The preferred return address equals the instruction address sampled with the request, for all three classes.
- R7: When requests coincide, program-counter alignment wins over branch target, and branch target wins over stack-pointer alignment.
- R8: All outputs are registered with one cycle of latency. `excValid` is high for exactly the cycle after each request cycle. In a cycle with no exception, every output is zero and the class reads 0.
- R9: While `rstN` is low, every output is zero, asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Qualifies `instAddr` for the alignment check |
| instAddr | input | 64 | Address of the current instruction |
| spMisalignReq | input | 1 | Stack-pointer misalignment request |
| btReq | input | 1 | Branch-target violation request |
| btType | input | 2 | Branch type of the violating branch |
| curLevel | input | 2 | Current exception level, 0 to 3 |
| el2Enable | input | 1 | Level 2 is enabled in the current state |
| trapGeneral | input | 1 | Trap-general control bit |
| excValid | output | 1 | One-cycle strobe for a new exception record |
| excClass | output | 2 | 0 none, 1 PC alignment, 2 branch target, 3 SP alignment |
| targetLevel | output | 2 | Level that takes the exception |
| retAddr | output | 64 | Preferred return address |
| faultVaddr | output | 64 | Faulting virtual address |
| syndrome | output | 25 | Exception syndrome |

## Verification
The hardest case to reach is the point where the two routing rules disagree. This happens at current level 1 with both level 2 enabled and trap-general set: an alignment fault goes to level 2, while a branch-target fault stays at level 1. A second hard case is a cycle where several requests coincide and the lower-priority class would route differently. The stimulus table places those exact input combinations side by side, including all three requests at once and a branch-target request paired with a stack-pointer request at level 1. Directed cycles then cover a misaligned address with `instValid` low and a reset asserted while a record is still on the outputs.

// File: rtl/excRouterPkg.sv
package excRouterPkg;

  localparam int LVL_W = 2;

  typedef enum logic [1:0] {
    EXC_NONE       = 2'd0,
    EXC_PC_ALIGN   = 2'd1,
    EXC_BRANCH_TGT = 2'd2,
    EXC_SP_ALIGN   = 2'd3
  } excClass_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic             load;
    excClass_e        cls;
    logic [LVL_W-1:0] tgtLevel;
  } ctlStrobe_t;

  // Routing used by both alignment classes
  function automatic logic [LVL_W-1:0] alignRoute(
    input logic [LVL_W-1:0] cur,
    input logic             el2En,
    input logic             trapGen
  );
    if (cur > LVL_W'(1))       return cur;
    else if (el2En && trapGen) return LVL_W'(2);
    else                       return LVL_W'(1);
  endfunction

  // Routing used by the branch-target class
  function automatic logic [LVL_W-1:0] branchRoute(
    input logic [LVL_W-1:0] cur,
    input logic             el2En,
    input logic             trapGen
  );
    if (cur == '0 && el2En && trapGen) return LVL_W'(2);
    else if (cur > LVL_W'(1))          return cur;
    else                               return LVL_W'(1);
  endfunction

endpackage

// File: rtl/excRouterCtrl.sv
module excRouterCtrl
  import excRouterPkg::*;
#(
  parameter int ALIGN_BITS = 2
) (
  input  logic                  instValid,
  input  logic [ALIGN_BITS-1:0] pcLow,
  input  logic                  spReq,
  input  logic                  btReq,
  input  logic [LVL_W-1:0]      curLevel,
  input  logic                  el2Enable,
  input  logic                  trapGeneral,
  output ctlStrobe_t            strobe
);

  logic pcFault;
  logic [LVL_W-1:0] alignTgt;
  logic [LVL_W-1:0] branchTgt;

  assign pcFault   = instValid && (pcLow != '0);
  assign alignTgt  = alignRoute(curLevel, el2Enable, trapGeneral);
  assign branchTgt = branchRoute(curLevel, el2Enable, trapGeneral);

  // Fixed priority: PC alignment, then branch target, then SP alignment
  always_comb begin
    strobe = '{load: 1'b0, cls: EXC_NONE, tgtLevel: '0};
    if (pcFault) begin
      strobe.load     = 1'b1;
      strobe.cls      = EXC_PC_ALIGN;
      strobe.tgtLevel = alignTgt;
    end else if (btReq) begin
      strobe.load     = 1'b1;
      strobe.cls      = EXC_BRANCH_TGT;
      strobe.tgtLevel = branchTgt;
    end else if (spReq) begin
      strobe.load     = 1'b1;
      strobe.cls      = EXC_SP_ALIGN;
      strobe.tgtLevel = alignTgt;
    end
  end

endmodule

// File: rtl/excRouterDatapath.sv
module excRouterDatapath
  import excRouterPkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SYN_W  = 25,
  parameter int BT_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [BT_W-1:0]   btType,
  output logic              excValid,
  output logic [1:0]        excClass,
  output logic [LVL_W-1:0]  targetLevel,
  output logic [ADDR_W-1:0] retAddr,
  output logic [ADDR_W-1:0] faultVaddr,
  output logic [SYN_W-1:0]  syndrome
);

  localparam int PAD_W = SYN_W - BT_W;

  logic [SYN_W-1:0]  synNext;
  logic [ADDR_W-1:0] vaNext;

  // Branch type in the low bits, reserved upper bits zero
  generate
    if (PAD_W > 0) begin : g_pad
      assign synNext = (strobe.cls == EXC_BRANCH_TGT) ? {{PAD_W{1'b0}}, btType} : '0;
    end else begin : g_nopad
      assign synNext = (strobe.cls == EXC_BRANCH_TGT) ? btType[SYN_W-1:0] : '0;
    end
  endgenerate

  assign vaNext = (strobe.cls == EXC_PC_ALIGN) ? instAddr : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excValid    <= 1'b0;
      excClass    <= EXC_NONE;
      targetLevel <= '0;
      retAddr     <= '0;
      faultVaddr  <= '0;
      syndrome    <= '0;
    end else if (strobe.load) begin
      excValid    <= 1'b1;
      excClass    <= strobe.cls;
      targetLevel <= strobe.tgtLevel;
      retAddr     <= instAddr;
      faultVaddr  <= vaNext;
      syndrome    <= synNext;
    end else begin
      excValid    <= 1'b0;
      excClass    <= EXC_NONE;
      targetLevel <= '0;
      retAddr     <= '0;
      faultVaddr  <= '0;
      syndrome    <= '0;
    end
  end

endmodule

// File: rtl/excRouter.sv
module excRouter
  import excRouterPkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int SYN_W      = 25,
  parameter int BT_W       = 2,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic              spMisalignReq,
  input  logic              btReq,
  input  logic [BT_W-1:0]   btType,
  input  logic [1:0]        curLevel,
  input  logic              el2Enable,
  input  logic              trapGeneral,
  output logic              excValid,
  output logic [1:0]        excClass,
  output logic [1:0]        targetLevel,
  output logic [ADDR_W-1:0] retAddr,
  output logic [ADDR_W-1:0] faultVaddr,
  output logic [SYN_W-1:0]  syndrome
);

  ctlStrobe_t strobe;

  excRouterCtrl #(.ALIGN_BITS(ALIGN_BITS)) ctrl_i (
    .instValid  (instValid),
    .pcLow      (instAddr[ALIGN_BITS-1:0]),
    .spReq      (spMisalignReq),
    .btReq      (btReq),
    .curLevel   (curLevel),
    .el2Enable  (el2Enable),
    .trapGeneral(trapGeneral),
    .strobe     (strobe)
  );

  excRouterDatapath #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .BT_W(BT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .instAddr   (instAddr),
    .btType     (btType),
    .excValid   (excValid),
    .excClass   (excClass),
    .targetLevel(targetLevel),
    .retAddr    (retAddr),
    .faultVaddr (faultVaddr),
    .syndrome   (syndrome)
  );

endmodule

// File: rtl/excRouterChk.sv
module excRouterChk #(
  parameter int ADDR_W     = 64,
  parameter int SYN_W      = 25,
  parameter int BT_W       = 2,
  parameter int ALIGN_BITS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [ADDR_W-1:0] instAddr,
  input logic              spMisalignReq,
  input logic              btReq,
  input logic [BT_W-1:0]   btType,
  input logic [1:0]        curLevel,
  input logic              el2Enable,
  input logic              trapGeneral,
  input logic              excValid,
  input logic [1:0]        excClass,
  input logic [1:0]        targetLevel,
  input logic [ADDR_W-1:0] retAddr,
  input logic [ADDR_W-1:0] faultVaddr,
  input logic [SYN_W-1:0]  syndrome
);

  logic pcBad;
  logic anyReq;
  assign pcBad  = instValid && (instAddr[ALIGN_BITS-1:0] != '0);
  assign anyReq = pcBad || btReq || spMisalignReq;

  assert_pc_fault_R1: assert property (@(posedge clk) disable iff (!rstN)
    pcBad |=> (excValid && excClass == 2'd1 && faultVaddr == $past(instAddr)));

  assert_sp_route_R2: assert property (@(posedge clk) disable iff (!rstN)
    (spMisalignReq && !pcBad && !btReq && curLevel > 2'd1) |=> (targetLevel == $past(curLevel)));

  assert_bt_route_R3: assert property (@(posedge clk) disable iff (!rstN)
    (btReq && !pcBad && curLevel == 2'd1) |=> (targetLevel == 2'd1));

  assert_bt_syndrome_R4: assert property (@(posedge clk) disable iff (!rstN)
    (btReq && !pcBad) |=> (syndrome[BT_W-1:0] == $past(btType) && syndrome[SYN_W-1:BT_W] == '0));

  assert_ret_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> (retAddr == $past(instAddr)));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> (!excValid && excClass == 2'd0 && targetLevel == 2'd0 && syndrome == '0));

endmodule

bind excRouter excRouterChk #(
  .ADDR_W(ADDR_W), .SYN_W(SYN_W), .BT_W(BT_W), .ALIGN_BITS(ALIGN_BITS)
) chk_i (
  .clk(clk), .rstN(rstN), .instValid(instValid), .instAddr(instAddr),
  .spMisalignReq(spMisalignReq), .btReq(btReq), .btType(btType),
  .curLevel(curLevel), .el2Enable(el2Enable), .trapGeneral(trapGeneral),
  .excValid(excValid), .excClass(excClass), .targetLevel(targetLevel),
  .retAddr(retAddr), .faultVaddr(faultVaddr), .syndrome(syndrome)
);

// File: tb/excRouter_tb.sv
module excRouter_tb_top;

  typedef struct packed {
    logic [1:0] pcLow;
    logic       bt;
    logic [1:0] btT;
    logic       sp;
    logic [1:0] cur;
    logic       el2;
    logic       tg;
    logic [1:0] cls;
    logic [1:0] tgt;
  } vec_t;

  localparam int NV = 19;
  localparam logic [63:0] BASE = 64'h0000_7fa0_0000_1000;

  // pcLow, bt, btType, sp, cur, el2, tg -> expected class, target
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0},
    '{2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 2'd1},
    '{2'd2, 1'b0, 2'd0, 1'b0, 2'd1, 1'b1, 1'b1, 2'd1, 2'd2},
    '{2'd3, 1'b0, 2'd0, 1'b0, 2'd3, 1'b1, 1'b1, 2'd1, 2'd3},
    '{2'd2, 1'b0, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 2'd1, 2'd2},
    '{2'd1, 1'b0, 2'd0, 1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 2'd1},
    '{2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 2'd1},
    '{2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 1'b1, 2'd3, 2'd2},
    '{2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 1'b1, 2'd3, 2'd2},
    '{2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd3, 2'd3},
    '{2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd3, 2'd1},
    '{2'd0, 1'b1, 2'd3, 1'b0, 2'd0, 1'b1, 1'b1, 2'd2, 2'd2},
    '{2'd0, 1'b1, 2'd1, 1'b0, 2'd1, 1'b1, 1'b1, 2'd2, 2'd1},
    '{2'd0, 1'b1, 2'd2, 1'b0, 2'd2, 1'b1, 1'b1, 2'd2, 2'd2},
    '{2'd0, 1'b1, 2'd3, 1'b0, 2'd3, 1'b0, 1'b0, 2'd2, 2'd3},
    '{2'd0, 1'b1, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 2'd1},
    '{2'd1, 1'b1, 2'd3, 1'b1, 2'd1, 1'b1, 1'b1, 2'd1, 2'd2},
    '{2'd0, 1'b1, 2'd2, 1'b1, 2'd1, 1'b1, 1'b1, 2'd2, 2'd1},
    '{2'd2, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd1, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [63:0] instAddr = '0;
  logic        spMisalignReq = 1'b0;
  logic        btReq = 1'b0;
  logic [1:0]  btType = '0;
  logic [1:0]  curLevel = '0;
  logic        el2Enable = 1'b0;
  logic        trapGeneral = 1'b0;
  logic        excValid;
  logic [1:0]  excClass;
  logic [1:0]  targetLevel;
  logic [63:0] retAddr;
  logic [63:0] faultVaddr;
  logic [24:0] syndrome;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  excRouter dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instAddr(instAddr),
    .spMisalignReq(spMisalignReq), .btReq(btReq), .btType(btType),
    .curLevel(curLevel), .el2Enable(el2Enable), .trapGeneral(trapGeneral),
    .excValid(excValid), .excClass(excClass), .targetLevel(targetLevel),
    .retAddr(retAddr), .faultVaddr(faultVaddr), .syndrome(syndrome)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    check(excValid == 1'b0 && excClass == 2'd0 && targetLevel == 2'd0 &&
          retAddr == '0 && faultVaddr == '0 && syndrome == '0,
          tag, {excValid, excClass, targetLevel}, 64'd0);
  endtask

  task automatic quiet();
    instValid = 1'b0; spMisalignReq = 1'b0; btReq = 1'b0; btType = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R9: outputs held at zero in reset
    repeat (3) @(negedge clk);
    checkIdle("R9 reset");
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic logic [63:0] a = BASE + 64'(i) * 64'h10 + 64'(v.pcLow);
      automatic bit multi = (v.pcLow != 0) + v.bt + v.sp > 1;
      instValid = 1'b1; instAddr = a; btReq = v.bt; btType = v.btT;
      spMisalignReq = v.sp; curLevel = v.cur; el2Enable = v.el2; trapGeneral = v.tg;
      @(negedge clk);
      check(excValid == (v.cls != 0), "R8 valid", 64'(excValid), 64'(v.cls != 0));
      check(excClass == v.cls, multi ? "R7 class" : "R1 class", 64'(excClass), 64'(v.cls));
      check(targetLevel == v.tgt, (v.cls == 2) ? "R3 target" : "R2 target",
            64'(targetLevel), 64'(v.tgt));
      check(syndrome == ((v.cls == 2) ? 25'(v.btT) : 25'd0), "R4 syndrome",
            64'(syndrome), (v.cls == 2) ? 64'(v.btT) : 64'd0);
      check(faultVaddr == ((v.cls == 1) ? a : 64'd0), "R5 vaddr",
            faultVaddr, (v.cls == 1) ? a : 64'd0);
      check(retAddr == ((v.cls != 0) ? a : 64'd0), "R6 return",
            retAddr, (v.cls != 0) ? a : 64'd0);
    end

    // R1: misaligned address ignored when not qualified
    quiet();
    instAddr = BASE + 64'd3;
    @(negedge clk);
    checkIdle("R1 unqualified");

    // R8: strobe lasts exactly one cycle
    instValid = 1'b1; instAddr = BASE + 64'd2; curLevel = 2'd0; el2Enable = 1'b0;
    @(negedge clk);
    check(excValid == 1'b1, "R8 strobe high", 64'(excValid), 64'd1);
    quiet();
    @(negedge clk);
    checkIdle("R8 strobe drop");

    // R9: asynchronous reset clears a live record
    btReq = 1'b1; btType = 2'd3; curLevel = 2'd2;
    @(negedge clk);
    check(excValid == 1'b1 && syndrome == 25'd3, "R4 before reset", 64'(syndrome), 64'd3);
    quiet();
    #2 rstN = 1'b0;
    #1 checkIdle("R9 async reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R9 after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule